// File: doc/BRIEF.md
# Segment Address Translator with Bounds Protection

This block turns a logical address, given as a segment selector and a byte offset, into a physical address. It does so through a small segment descriptor table held in flip-flops. Each descriptor carries a residency flag, a base address, a segment length and a dirty flag. Software fills the descriptors through a table write port. The requester then presents one translation per cycle, and the result appears one clock later.

Every access is checked before an address is formed. An access to a descriptor whose residency flag is clear is reported as an absent-segment fault. An offset that reaches or passes the segment length is reported as a bounds fault. A faulting access produces no address. A request selects one of two formation modes. In flat mode the base is added to the offset. In paged mode the base is taken as the start of a page table, and the block emits the address of the page table entry for the page that holds the offset, together with the in-page offset, for a downstream page lookup. A write access that passes both checks marks its descriptor dirty.

Top module: `seg_translator`

## Requirements
- R1: After reset every descriptor is non-resident and clean, and all response outputs are low.
- R2: The descriptor is selected by `req_seg`. The response to a request with `req_valid` high appears on the outputs in the following cycle with `rsp_valid` high, and `rsp_valid` is low in the cycle after a cycle with no request.
- R3: In flat mode (`req_paged` = 0), an access that does not fault returns `rsp_addr` = base + offset, taken modulo 2^24, with `rsp_page_off` = 0.
- R4: An offset greater than or equal to the descriptor length raises `rsp_fault_limit` and forces `rsp_addr` and `rsp_page_off` to 0. A length of 0 rejects every offset, and a length of 65536 accepts every offset.
- R5: An access to a non-resident descriptor raises `rsp_fault_absent` with `rsp_fault_limit` low, whatever the offset, and returns address 0.
- R6: In paged mode (`req_paged` = 1), an access that does not fault returns `rsp_addr` = base + 4 × offset[15:10], taken modulo 2^24, and `rsp_page_off` = offset[9:0].
- R7: A write access (`req_write` = 1) that raises no fault sets the descriptor's dirty flag. A write access that faults leaves the flag unchanged.
- R8: A table write in the same cycle as a translation of the same descriptor does not affect that translation, which uses the old descriptor. The table write also overrides any dirty-flag update from that translation.
- R9: `rsp_modified` reports the descriptor's dirty flag as it stood before the access, and it does so for faulting accesses too.
- R10: At most one fault flag is high at a time, and a fault flag is high only together with `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tw_en | input | 1 | Descriptor write strobe |
| tw_idx | input | 4 | Descriptor index to write |
| tw_present | input | 1 | Residency flag to store |
| tw_modified | input | 1 | Dirty flag to store |
| tw_base | input | 24 | Segment base or page table start |
| tw_length | input | 17 | Segment length in bytes (0 to 65536) |
| req_valid | input | 1 | Translation request strobe |
| req_write | input | 1 | Request is a write access |
| req_paged | input | 1 | 0 selects flat mode, 1 selects paged mode |
| req_seg | input | 4 | Segment selector |
| req_off | input | 16 | Byte offset within the segment |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_fault_absent | output | 1 | Segment not resident |
| rsp_fault_limit | output | 1 | Offset outside segment bounds |
| rsp_modified | output | 1 | Dirty flag before this access |
| rsp_addr | output | 24 | Physical address or page table entry address |
| rsp_page_off | output | 10 | Offset within the page (paged mode) |

## Verification
The bench uses the default parameters: a 4-bit selector with 16 descriptors, a 16-bit offset, a 24-bit physical address and 1 KiB pages. With these values a few vectors reach the real edges. A length of 65536 lets offset 0xFFFF pass. A length of 0 rejects offset 0. A base near the top of the 24-bit space makes the sum wrap. Offset 0xFC00 reaches the highest page index, 63. Directed sequences then cover dirty-flag marking on faulting and non-faulting writes, and a table write that collides with a translation of the same descriptor.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    // Outcome of the descriptor checks; absent outranks limit.
    typedef enum logic [1:0] {
        CHK_OK     = 2'd0,
        CHK_ABSENT = 2'd1,
        CHK_LIMIT  = 2'd2
    } chk_result_e;

    // Address formation variant selected per request.
    typedef enum logic {
        FORM_FLAT  = 1'b0,
        FORM_PAGED = 1'b1
    } form_mode_e;

endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table #(
    parameter int SEL_W  = 4,
    parameter int PA_W   = 24,
    parameter int LEN_W  = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    // write port
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_idx,
    input  logic             wr_present,
    input  logic             wr_modified,
    input  logic [PA_W-1:0]  wr_base,
    input  logic [LEN_W-1:0] wr_length,
    // dirty-flag set request
    input  logic             mark_en,
    input  logic [SEL_W-1:0] mark_idx,
    // combinational read port
    input  logic [SEL_W-1:0] rd_idx,
    output logic             rd_present,
    output logic             rd_modified,
    output logic [PA_W-1:0]  rd_base,
    output logic [LEN_W-1:0] rd_length
);

    localparam int ENTRIES = 1 << SEL_W;

    typedef struct packed {
        logic             present;
        logic             modified;
        logic [PA_W-1:0]  base;
        logic [LEN_W-1:0] length;
    } desc_t;

    desc_t tbl_d [ENTRIES];
    desc_t tbl_q [ENTRIES];

    // next-state: dirty marking first, table write last so it wins
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            tbl_d[i] = tbl_q[i];
        end
        if (mark_en) begin
            tbl_d[mark_idx].modified = 1'b1;
        end
        if (wr_en) begin
            tbl_d[wr_idx].present  = wr_present;
            tbl_d[wr_idx].modified = wr_modified;
            tbl_d[wr_idx].base     = wr_base;
            tbl_d[wr_idx].length   = wr_length;
        end
    end

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tbl_q[g] <= '0;
                end else begin
                    tbl_q[g] <= tbl_d[g];
                end
            end
        end
    endgenerate

    // read returns the registered (old) descriptor
    always_comb begin
        rd_present  = tbl_q[rd_idx].present;
        rd_modified = tbl_q[rd_idx].modified;
        rd_base     = tbl_q[rd_idx].base;
        rd_length   = tbl_q[rd_idx].length;
    end

    // A non-colliding mark must leave the flag set on the next cycle.
    assert_mark_sets_dirty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_en && !(wr_en && wr_idx == mark_idx))
        |=> tbl_q[$past(mark_idx)].modified);

    // A table write stores exactly the supplied fields, mark or not.
    assert_write_overrides_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tbl_q[$past(wr_idx)].modified == $past(wr_modified))
               && (tbl_q[$past(wr_idx)].base == $past(wr_base))
               && (tbl_q[$past(wr_idx)].present == $past(wr_present)));

endmodule

// File: rtl/seg_bound_check.sv
module seg_bound_check
    import seg_xlate_pkg::*;
#(
    parameter int OFF_W = 16,
    parameter int LEN_W = 17
) (
    input  logic             present,
    input  logic [LEN_W-1:0] length,
    input  logic [OFF_W-1:0] offset,
    output chk_result_e      result
);

    localparam int PAD_W = LEN_W - OFF_W;

    logic [LEN_W-1:0] off_ext;
    logic             beyond;

    generate
        if (PAD_W > 0) begin : g_pad
            assign off_ext = {{PAD_W{1'b0}}, offset};
        end else begin : g_nopad
            assign off_ext = offset[LEN_W-1:0];
        end
    endgenerate

    assign beyond = (off_ext >= length);

    always_comb begin
        if (!present) begin
            result = CHK_ABSENT;
        end else if (beyond) begin
            result = CHK_LIMIT;
        end else begin
            result = CHK_OK;
        end
    end

    // Absence is reported whatever the bounds say.
    always_comb begin
        if (!present) begin
            assert_absent_first_R5: assert (result == CHK_ABSENT);
        end
    end

endmodule

// File: rtl/seg_addr_form.sv
module seg_addr_form
    import seg_xlate_pkg::*;
#(
    parameter int OFF_W    = 16,
    parameter int PA_W     = 24,
    parameter int PG_OFF_W = 10,
    parameter int PTE_SH   = 2
) (
    input  form_mode_e          mode,
    input  logic [PA_W-1:0]     base,
    input  logic [OFF_W-1:0]    offset,
    output logic [PA_W-1:0]     addr,
    output logic [PG_OFF_W-1:0] page_off
);

    localparam int PG_NUM_W = OFF_W - PG_OFF_W;

    logic [PA_W-1:0]     off_wide;
    logic [PA_W-1:0]     pte_step;
    logic [PG_NUM_W-1:0] page_num;

    assign page_num = offset[OFF_W-1:PG_OFF_W];
    assign off_wide = PA_W'(offset);
    assign pte_step = PA_W'(page_num) << PTE_SH;

    always_comb begin
        unique case (mode)
            FORM_PAGED: begin
                addr     = base + pte_step;
                page_off = offset[PG_OFF_W-1:0];
            end
            default: begin
                addr     = base + off_wide;
                page_off = '0;
            end
        endcase
    end

endmodule

// File: rtl/seg_translator.sv
module seg_translator
    import seg_xlate_pkg::*;
#(
    parameter int SEL_W    = 4,
    parameter int OFF_W    = 16,
    parameter int PA_W     = 24,
    parameter int PG_OFF_W = 10,
    parameter int PTE_SH   = 2,
    parameter int LEN_W    = OFF_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tw_en,
    input  logic [SEL_W-1:0]    tw_idx,
    input  logic                tw_present,
    input  logic                tw_modified,
    input  logic [PA_W-1:0]     tw_base,
    input  logic [LEN_W-1:0]    tw_length,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic                req_paged,
    input  logic [SEL_W-1:0]    req_seg,
    input  logic [OFF_W-1:0]    req_off,
    output logic                rsp_valid,
    output logic                rsp_fault_absent,
    output logic                rsp_fault_limit,
    output logic                rsp_modified,
    output logic [PA_W-1:0]     rsp_addr,
    output logic [PG_OFF_W-1:0] rsp_page_off
);

    typedef struct packed {
        logic                valid;
        logic                f_absent;
        logic                f_limit;
        logic                modified;
        logic [PA_W-1:0]     addr;
        logic [PG_OFF_W-1:0] page_off;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic                d_present;
    logic                d_modified;
    logic [PA_W-1:0]     d_base;
    logic [LEN_W-1:0]    d_length;
    chk_result_e         chk;
    logic [PA_W-1:0]     form_addr;
    logic [PG_OFF_W-1:0] form_poff;
    logic                mark_en;

    seg_desc_table #(
        .SEL_W (SEL_W),
        .PA_W  (PA_W),
        .LEN_W (LEN_W)
    ) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (tw_en),
        .wr_idx      (tw_idx),
        .wr_present  (tw_present),
        .wr_modified (tw_modified),
        .wr_base     (tw_base),
        .wr_length   (tw_length),
        .mark_en     (mark_en),
        .mark_idx    (req_seg),
        .rd_idx      (req_seg),
        .rd_present  (d_present),
        .rd_modified (d_modified),
        .rd_base     (d_base),
        .rd_length   (d_length)
    );

    seg_bound_check #(
        .OFF_W (OFF_W),
        .LEN_W (LEN_W)
    ) u_check (
        .present (d_present),
        .length  (d_length),
        .offset  (req_off),
        .result  (chk)
    );

    seg_addr_form #(
        .OFF_W    (OFF_W),
        .PA_W     (PA_W),
        .PG_OFF_W (PG_OFF_W),
        .PTE_SH   (PTE_SH)
    ) u_form (
        .mode     (form_mode_e'(req_paged)),
        .base     (d_base),
        .offset   (req_off),
        .addr     (form_addr),
        .page_off (form_poff)
    );

    assign mark_en = req_valid && req_write && (chk == CHK_OK);

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid    = 1'b1;
            rsp_d.modified = d_modified;
            rsp_d.f_absent = (chk == CHK_ABSENT);
            rsp_d.f_limit  = (chk == CHK_LIMIT);
            if (chk == CHK_OK) begin
                rsp_d.addr     = form_addr;
                rsp_d.page_off = form_poff;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid        = rsp_q.valid;
    assign rsp_fault_absent = rsp_q.f_absent;
    assign rsp_fault_limit  = rsp_q.f_limit;
    assign rsp_modified     = rsp_q.modified;
    assign rsp_addr         = rsp_q.addr;
    assign rsp_page_off     = rsp_q.page_off;

    assert_resp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rsp_valid == $past(req_valid)));

    assert_fault_no_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault_limit || rsp_fault_absent) |-> (rsp_addr == '0 && rsp_page_off == '0));

    assert_single_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_fault_absent && rsp_fault_limit) && ((rsp_fault_absent || rsp_fault_limit) -> rsp_valid));

    assert_flat_no_page_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_paged) |=> (rsp_page_off == '0));

endmodule

// File: tb/test_seg_translator.sv
module test_seg_translator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tw_en = 1'b0;
    logic [3:0]  tw_idx = '0;
    logic        tw_present = 1'b0;
    logic        tw_modified = 1'b0;
    logic [23:0] tw_base = '0;
    logic [16:0] tw_length = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_paged = 1'b0;
    logic [3:0]  req_seg = '0;
    logic [15:0] req_off = '0;
    logic        rsp_valid, rsp_fault_absent, rsp_fault_limit, rsp_modified;
    logic [23:0] rsp_addr;
    logic [9:0]  rsp_page_off;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;   // 125 MHz

    seg_translator i_seg_translator (
        .clk(clk), .rst_n(rst_n),
        .tw_en(tw_en), .tw_idx(tw_idx), .tw_present(tw_present),
        .tw_modified(tw_modified), .tw_base(tw_base), .tw_length(tw_length),
        .req_valid(req_valid), .req_write(req_write), .req_paged(req_paged),
        .req_seg(req_seg), .req_off(req_off),
        .rsp_valid(rsp_valid), .rsp_fault_absent(rsp_fault_absent),
        .rsp_fault_limit(rsp_fault_limit), .rsp_modified(rsp_modified),
        .rsp_addr(rsp_addr), .rsp_page_off(rsp_page_off)
    );

    typedef struct packed {
        logic [3:0]  seg;
        logic [15:0] off;
        logic        paged;
        logic        fa;
        logic        fl;
        logic        mod;
        logic [23:0] addr;
        logic [9:0]  poff;
    } vec_t;

    // seg, off, paged, absent, limit, dirty, addr, page_off
    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 24'h001000, 10'h000}, // R3
        '{4'd0,  16'h00FF, 1'b0, 1'b0, 1'b0, 1'b0, 24'h0010FF, 10'h000}, // R3 last byte
        '{4'd0,  16'h0100, 1'b0, 1'b0, 1'b1, 1'b0, 24'h000000, 10'h000}, // R4 at length
        '{4'd1,  16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b1, 24'h02FFFF, 10'h000}, // R4 full length, R9
        '{4'd2,  16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 24'h000000, 10'h000}, // R5
        '{4'd2,  16'h0200, 1'b0, 1'b1, 1'b0, 1'b0, 24'h000000, 10'h000}, // R5 over limit too
        '{4'd3,  16'h07FF, 1'b1, 1'b0, 1'b0, 1'b0, 24'h100004, 10'h3FF}, // R6
        '{4'd3,  16'h0400, 1'b1, 1'b0, 1'b0, 1'b0, 24'h100004, 10'h000}, // R6
        '{4'd3,  16'h0800, 1'b1, 1'b0, 1'b1, 1'b0, 24'h000000, 10'h000}, // R4 paged
        '{4'd1,  16'hFC00, 1'b1, 1'b0, 1'b0, 1'b1, 24'h0200FC, 10'h000}, // R6 top page
        '{4'd15, 16'h01FF, 1'b0, 1'b0, 1'b0, 1'b0, 24'h0000FF, 10'h000}, // R3 wrap
        '{4'd4,  16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 24'h000000, 10'h000}, // R4 zero length
        '{4'd0,  16'h0010, 1'b1, 1'b0, 1'b0, 1'b0, 24'h001000, 10'h010}  // R6 page 0
    };

    task automatic check_rsp(input string tag, input logic ev, input logic efa,
                             input logic efl, input logic emod,
                             input logic [23:0] eaddr, input logic [9:0] epoff);
        n_checks++;
        if (rsp_valid !== ev || rsp_fault_absent !== efa || rsp_fault_limit !== efl ||
            rsp_modified !== emod || rsp_addr !== eaddr || rsp_page_off !== epoff) begin
            n_fails++;
            $display("FAIL %s: got v=%b fa=%b fl=%b mod=%b addr=%h poff=%h, exp v=%b fa=%b fl=%b mod=%b addr=%h poff=%h",
                     tag, rsp_valid, rsp_fault_absent, rsp_fault_limit, rsp_modified,
                     rsp_addr, rsp_page_off, ev, efa, efl, emod, eaddr, epoff);
        end
    endtask

    task automatic put_desc(input logic [3:0] idx, input logic pr, input logic md,
                            input logic [23:0] b, input logic [16:0] len);
        tw_en = 1'b1; tw_idx = idx; tw_present = pr; tw_modified = md;
        tw_base = b; tw_length = len;
    endtask

    task automatic put_req(input logic [3:0] s, input logic [15:0] o,
                           input logic wr, input logic pg);
        req_valid = 1'b1; req_seg = s; req_off = o; req_write = wr; req_paged = pg;
    endtask

    // Apply whatever is staged for one edge, then sample at the next falling edge.
    task automatic step;
        @(negedge clk);
        tw_en = 1'b0;
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic load(input logic [3:0] idx, input logic pr, input logic md,
                        input logic [23:0] b, input logic [16:0] len);
        put_desc(idx, pr, md, b, len);
        step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: outputs low after reset
        check_rsp("R1 reset outputs", 0, 0, 0, 0, 24'h0, 10'h0);
        // R1: table cleared, so descriptor 0 is non-resident
        put_req(4'd0, 16'h0, 1'b0, 1'b0); step();
        check_rsp("R1 table cleared", 1, 1, 0, 0, 24'h0, 10'h0);
        // R2: idle cycle gives no response
        step();
        check_rsp("R2 idle", 0, 0, 0, 0, 24'h0, 10'h0);

        load(4'd0,  1, 0, 24'h001000, 17'h00100);
        load(4'd1,  1, 1, 24'h020000, 17'h10000);
        load(4'd2,  0, 0, 24'h005000, 17'h00100);
        load(4'd3,  1, 0, 24'h100000, 17'h00800);
        load(4'd4,  1, 0, 24'h040000, 17'h00000);
        load(4'd15, 1, 0, 24'hFFFF00, 17'h00200);

        for (int k = 0; k < NV; k++) begin
            put_req(VECS[k].seg, VECS[k].off, 1'b0, VECS[k].paged);
            step();
            check_rsp($sformatf("vector %0d (R2..R6,R9)", k), 1, VECS[k].fa,
                      VECS[k].fl, VECS[k].mod, VECS[k].addr, VECS[k].poff);
        end

        // R7/R9: clean write reports old flag 0, then flag reads back 1
        put_req(4'd0, 16'h0020, 1'b1, 1'b0); step();
        check_rsp("R7 write access", 1, 0, 0, 0, 24'h001020, 10'h0);
        put_req(4'd0, 16'h0000, 1'b0, 1'b0); step();
        check_rsp("R7 dirty set", 1, 0, 0, 1, 24'h001000, 10'h0);
        // R7: faulting write (limit) leaves flag clean
        put_req(4'd3, 16'h0900, 1'b1, 1'b0); step();
        check_rsp("R7 limit write", 1, 0, 1, 0, 24'h0, 10'h0);
        put_req(4'd3, 16'h0000, 1'b0, 1'b0); step();
        check_rsp("R7 limit write no dirty", 1, 0, 0, 0, 24'h100000, 10'h0);
        // R7: faulting write (absent) leaves flag clean
        put_req(4'd2, 16'h0000, 1'b1, 1'b0); step();
        put_req(4'd2, 16'h0000, 1'b0, 1'b0); step();
        check_rsp("R7 absent write no dirty", 1, 1, 0, 0, 24'h0, 10'h0);
        // R8: same-cycle load and translation sees old descriptor
        put_desc(4'd5, 1, 0, 24'h300000, 17'h00100);
        put_req(4'd5, 16'h0010, 1'b0, 1'b0); step();
        check_rsp("R8 old entry used", 1, 1, 0, 0, 24'h0, 10'h0);
        put_req(4'd5, 16'h0010, 1'b0, 1'b0); step();
        check_rsp("R8 new entry visible", 1, 0, 0, 0, 24'h300010, 10'h0);
        // R8: table write wins over dirty marking of the same descriptor
        put_desc(4'd0, 1, 0, 24'h004000, 17'h00100);
        put_req(4'd0, 16'h0000, 1'b1, 1'b0); step();
        check_rsp("R8 collide old", 1, 0, 0, 1, 24'h001000, 10'h0);
        put_req(4'd0, 16'h0000, 1'b0, 1'b0); step();
        check_rsp("R8 write wins", 1, 0, 0, 0, 24'h004000, 10'h0);
        // R10: no fault flags with no request
        step();
        check_rsp("R10 quiet", 0, 0, 0, 0, 24'h0, 10'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 8);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout, exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule